// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block sits between the event flags of a UART and the single interrupt line seen by the processor. It takes condition flags from the receiver, the transmitter, the line error logic, the modem status logic and a busy-detect condition, and gates each one with its enable bit. It then chooses the most urgent pending source and shows it as a 4-bit identity code. Software reads that code to find out why it was interrupted. Two bits above the code report whether the FIFOs are enabled.

Four sources are event latches, each set by a one-cycle pulse and cleared by the bus access that services it: busy detect, line status, character timeout and modem status. Received-data-available follows the receive level comparison directly. The transmit-empty source is tracked by a three-state machine with states `TXS_IDLE`, `TXS_ARMED` and `TXS_ACKED`. The machine moves as follows:

- `TXS_IDLE` to `TXS_ARMED` when the transmit condition is true.
- `TXS_ARMED` to `TXS_ACKED` on an acknowledge, which is a holding-register write or an identity read while the code shows transmit-empty.
- `TXS_ACKED` to `TXS_ARMED` on a 0-to-1 change of the transmit enable.
- `TXS_ARMED` or `TXS_ACKED` to `TXS_IDLE` whenever the condition is false.

When the programmable threshold mode is on, the transmit condition is the FIFO-below-threshold flag instead of the holding-empty flag.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with all inputs low, `iir_o` reads 8'h01 and `irq_o` is low.
- R2: `irq_o` is high exactly when `iir_o[3:0]` differs from 4'b0001. The identity codes are:
  - 4'b0111 for busy detect
  - 4'b0110 for line status
  - 4'b0100 for received data
  - 4'b1100 for character timeout
  - 4'b0010 for transmit empty
  - 4'b0000 for modem status
  - 4'b0001 when nothing is pending.
- R3: When several sources are pending and enabled, the code shown is the first one in this order: busy, line status, received data, timeout, transmit empty, modem.
- R4: Each source is gated by its enable input:
  - `en_rxd_i` gates received data and timeout.
  - `en_txe_i` gates transmit empty.
  - `en_line_i` gates line status.
  - `en_modem_i` gates modem status.
  - Busy detect is never gated.
  - A masked latched source stays pending and appears as soon as its enable is raised.
- R5: Line status:
  - A `line_err_i` pulse makes line status pending from the next cycle.
  - A `lsr_rd_i` pulse clears it from the next cycle.
  - If a set and a clear arrive in the same cycle, the set wins.
- R6: Received data follows `rx_trig_i` in the same cycle. A `rx_timeout_i` pulse makes timeout pending from the next cycle, and a `rbr_rd_i` pulse clears it.
- R7: Transmit empty:
  - It becomes pending the cycle after its condition is seen true.
  - It is cleared by a `thr_wr_i` pulse, or by an `iir_rd_i` pulse while the code shows 4'b0010.
  - It stays clear until the condition falls and rises again, or `en_txe_i` goes from 0 to 1.
- R8: When `en_ptime_i` and `fifo_en_i` are both high, the transmit condition is `tx_below_thr_i` and `thr_empty_i` is ignored. Otherwise the condition is `thr_empty_i` and `tx_below_thr_i` is ignored.
- R9: Busy detect:
  - A `lcr_wr_i` pulse while `uart_busy_i` is high makes busy detect pending from the next cycle.
  - The same pulse while `uart_busy_i` is low has no effect.
  - A `usr_rd_i` pulse clears it.
- R10: A `modem_delta_i` pulse makes modem status pending from the next cycle, and a `msr_rd_i` pulse clears it.
- R11: `iir_o[7:6]` reads 2'b11 when `fifo_en_i` is high and 2'b00 when it is low. `iir_o[5:4]` always reads 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_rxd_i | input | 1 | Enable for received data and timeout |
| en_txe_i | input | 1 | Enable for transmit empty |
| en_line_i | input | 1 | Enable for line status |
| en_modem_i | input | 1 | Enable for modem status |
| en_ptime_i | input | 1 | Selects programmable threshold mode for transmit empty |
| fifo_en_i | input | 1 | FIFOs enabled |
| rx_trig_i | input | 1 | Receive level at or above trigger (level) |
| rx_timeout_i | input | 1 | Character timeout event (pulse) |
| rbr_rd_i | input | 1 | Receive buffer read (pulse) |
| line_err_i | input | 1 | Line error event (pulse) |
| lsr_rd_i | input | 1 | Line status read (pulse) |
| thr_empty_i | input | 1 | Holding register / transmit FIFO empty (level) |
| tx_below_thr_i | input | 1 | Transmit FIFO at or below threshold (level) |
| thr_wr_i | input | 1 | Holding register write (pulse) |
| iir_rd_i | input | 1 | Identity register read (pulse) |
| modem_delta_i | input | 1 | Modem status change event (pulse) |
| msr_rd_i | input | 1 | Modem status read (pulse) |
| lcr_wr_i | input | 1 | Line control write (pulse) |
| uart_busy_i | input | 1 | UART busy (level) |
| usr_rd_i | input | 1 | Status register read (pulse) |
| irq_o | output | 1 | Interrupt request |
| iir_o | output | 8 | Identity register value |

## Verification
The main sweep raises every one of the 64 subsets of the six sources against all 16 enable masks, with the FIFOs both on and off. This shows whether the priority order, the enable gating and the flag bits are right for every pairing of sources. Directed sequences then cover the service paths:

- A line status set and clear in the same cycle, which separates set-wins from clear-wins.
- Acknowledging transmit empty, then re-arming it either by toggling its enable or by toggling its condition. This separates an event-driven source from a level-driven one.
- Threshold mode with one of its two qualifiers missing, to show that the correct transmit flag is chosen.
- A line control write with the busy flag low, to show that it leaves busy detect clear.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [3:0] {
        ID_MODEM   = 4'b0000,
        ID_NONE    = 4'b0001,
        ID_TXE     = 4'b0010,
        ID_RXDATA  = 4'b0100,
        ID_LINE    = 4'b0110,
        ID_BUSY    = 4'b0111,
        ID_TIMEOUT = 4'b1100
    } irq_id_e;

    typedef enum logic [1:0] {
        TXS_IDLE  = 2'd0,
        TXS_ARMED = 2'd1,
        TXS_ACKED = 2'd2
    } txs_e;

    // Source index equals priority rank: lower index wins.
    localparam int SRC_BUSY  = 0;
    localparam int SRC_LINE  = 1;
    localparam int SRC_RXD   = 2;
    localparam int SRC_TMO   = 3;
    localparam int SRC_TXE   = 4;
    localparam int SRC_MODEM = 5;
    localparam int N_SRC     = 6;

    // Event-latched sources.
    localparam int STK_BUSY  = 0;
    localparam int STK_LINE  = 1;
    localparam int STK_TMO   = 2;
    localparam int STK_MODEM = 3;
    localparam int N_STICKY  = 4;

    function automatic irq_id_e src_code(input int idx);
        irq_id_e c;
        case (idx)
            SRC_BUSY:  c = ID_BUSY;
            SRC_LINE:  c = ID_LINE;
            SRC_RXD:   c = ID_RXDATA;
            SRC_TMO:   c = ID_TIMEOUT;
            SRC_TXE:   c = ID_TXE;
            SRC_MODEM: c = ID_MODEM;
            default:   c = ID_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    logic pend_q;

    // A new event in the same cycle as a service access is kept.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pend_q <= 1'b0;
        end else if (set_i) begin
            pend_q <= 1'b1;
        end else if (clr_i) begin
            pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    AST_SET_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i |=> pend_o); // R5

    AST_CLR_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !set_i) |=> !pend_o); // R10

endmodule

// File: rtl/uart_irq_thre_fsm.sv
module uart_irq_thre_fsm
    import uart_irq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cond_i,
    input  logic en_i,
    input  logic ack_i,
    output logic pend_o
);

    txs_e state_q, state_d;
    logic en_q;
    logic en_rise;

    assign en_rise = en_i && !en_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= TXS_IDLE;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= en_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXS_IDLE: begin
                if (cond_i) state_d = TXS_ARMED;
            end
            TXS_ARMED: begin
                if (!cond_i)    state_d = TXS_IDLE;
                else if (ack_i) state_d = TXS_ACKED;
            end
            TXS_ACKED: begin
                if (!cond_i)      state_d = TXS_IDLE;
                else if (en_rise) state_d = TXS_ARMED;
            end
            default: state_d = TXS_IDLE;
        endcase
    end

    always_comb begin
        pend_o = (state_q == TXS_ARMED);
    end

    AST_ACK_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == TXS_ARMED && ack_i) |=> (state_q != TXS_ARMED)); // R7

    AST_NO_COND_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cond_i |=> !pend_o); // R7

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int N = N_SRC
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output irq_id_e      id_o
);

    always_comb begin
        grant_o = '0;
        id_o    = ID_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                id_o       = src_code(i);
            end
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant_o)); // R3

    AST_GRANT_REQUESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_o & ~req_i) == '0); // R3

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       en_rxd_i,
    input  logic       en_txe_i,
    input  logic       en_line_i,
    input  logic       en_modem_i,
    input  logic       en_ptime_i,
    input  logic       fifo_en_i,
    input  logic       rx_trig_i,
    input  logic       rx_timeout_i,
    input  logic       rbr_rd_i,
    input  logic       line_err_i,
    input  logic       lsr_rd_i,
    input  logic       thr_empty_i,
    input  logic       tx_below_thr_i,
    input  logic       thr_wr_i,
    input  logic       iir_rd_i,
    input  logic       modem_delta_i,
    input  logic       msr_rd_i,
    input  logic       lcr_wr_i,
    input  logic       uart_busy_i,
    input  logic       usr_rd_i,
    output logic       irq_o,
    output logic [7:0] iir_o
);

    logic [N_STICKY-1:0] stk_set, stk_clr, stk_pend;
    logic [N_SRC-1:0]    req, grant;
    irq_id_e             id;
    logic                ptime_on, txe_cond, txe_ack, txe_pend;

    always_comb begin
        stk_set            = '0;
        stk_clr            = '0;
        stk_set[STK_BUSY]  = lcr_wr_i && uart_busy_i;
        stk_clr[STK_BUSY]  = usr_rd_i;
        stk_set[STK_LINE]  = line_err_i;
        stk_clr[STK_LINE]  = lsr_rd_i;
        stk_set[STK_TMO]   = rx_timeout_i;
        stk_clr[STK_TMO]   = rbr_rd_i;
        stk_set[STK_MODEM] = modem_delta_i;
        stk_clr[STK_MODEM] = msr_rd_i;
    end

    for (genvar g = 0; g < N_STICKY; g++) begin : g_src
        uart_irq_sticky u_stk (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .set_i  (stk_set[g]),
            .clr_i  (stk_clr[g]),
            .pend_o (stk_pend[g])
        );
    end

    assign ptime_on = en_ptime_i && fifo_en_i;
    assign txe_cond = ptime_on ? tx_below_thr_i : thr_empty_i;
    assign txe_ack  = thr_wr_i || (iir_rd_i && (id == ID_TXE));

    uart_irq_thre_fsm u_txe (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cond_i (txe_cond),
        .en_i   (en_txe_i),
        .ack_i  (txe_ack),
        .pend_o (txe_pend)
    );

    always_comb begin
        req            = '0;
        req[SRC_BUSY]  = stk_pend[STK_BUSY];
        req[SRC_LINE]  = stk_pend[STK_LINE] && en_line_i;
        req[SRC_RXD]   = rx_trig_i && en_rxd_i;
        req[SRC_TMO]   = stk_pend[STK_TMO] && en_rxd_i;
        req[SRC_TXE]   = txe_pend && en_txe_i;
        req[SRC_MODEM] = stk_pend[STK_MODEM] && en_modem_i;
    end

    uart_irq_prio #(.N(N_SRC)) u_prio (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (req),
        .grant_o (grant),
        .id_o    (id)
    );

    assign iir_o = {fifo_en_i, fifo_en_i, 2'b00, id};
    assign irq_o = (id != ID_NONE);

    AST_BUSY_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stk_pend[STK_BUSY] |-> (iir_o[3:0] == ID_BUSY)); // R3

    AST_LINE_OVER_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stk_pend[STK_LINE] && en_line_i && !stk_pend[STK_BUSY]) |-> (iir_o[3:0] == ID_LINE)); // R3

    AST_QUIET_MEANS_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_o |-> (grant == '0)); // R2

    AST_IDLE_BUSY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lcr_wr_i && !uart_busy_i && !stk_pend[STK_BUSY]) |=> !stk_pend[STK_BUSY]); // R9

endmodule

// File: tb/test_uart_irq_ident.sv
`timescale 1ns/1ps
module test_uart_irq_ident;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic en_rxd, en_txe, en_line, en_modem, en_ptime, fifo_en;
    logic rx_trig, rx_timeout, rbr_rd, line_err, lsr_rd;
    logic thr_empty, tx_below, thr_wr, iir_rd;
    logic modem_delta, msr_rd, lcr_wr, uart_busy, usr_rd;
    logic irq;
    logic [7:0] iir;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    uart_irq_ident i_uart_irq_ident (
        .clk_i(clk), .rst_ni(rst_ni),
        .en_rxd_i(en_rxd), .en_txe_i(en_txe), .en_line_i(en_line),
        .en_modem_i(en_modem), .en_ptime_i(en_ptime), .fifo_en_i(fifo_en),
        .rx_trig_i(rx_trig), .rx_timeout_i(rx_timeout), .rbr_rd_i(rbr_rd),
        .line_err_i(line_err), .lsr_rd_i(lsr_rd),
        .thr_empty_i(thr_empty), .tx_below_thr_i(tx_below), .thr_wr_i(thr_wr),
        .iir_rd_i(iir_rd), .modem_delta_i(modem_delta), .msr_rd_i(msr_rd),
        .lcr_wr_i(lcr_wr), .uart_busy_i(uart_busy), .usr_rd_i(usr_rd),
        .irq_o(irq), .iir_o(iir)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic check_id(input string tag, input logic [3:0] exp);
        check8(tag, {fifo_en, fifo_en, 2'b00, exp} , iir);
        check8({tag, " irq"}, {7'd0, irq}, {7'd0, exp != 4'b0001});
    endtask

    task automatic set_en(input logic [7:0] m);
        en_rxd = m[0]; en_txe = m[1]; en_line = m[2]; en_modem = m[3]; en_ptime = m[7];
    endtask

    task automatic quiet();
        rx_trig = 0; rx_timeout = 0; rbr_rd = 0; line_err = 0; lsr_rd = 0;
        thr_empty = 0; tx_below = 0; thr_wr = 0; iir_rd = 0;
        modem_delta = 0; msr_rd = 0; lcr_wr = 0; uart_busy = 0; usr_rd = 0;
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        quiet();
        @(negedge clk);
        @(negedge clk);
        rst_ni = 1'b1;
    endtask

    task automatic clear_pulses();
        rx_timeout = 0; rbr_rd = 0; line_err = 0; lsr_rd = 0; thr_wr = 0;
        iir_rd = 0; modem_delta = 0; msr_rd = 0; lcr_wr = 0; usr_rd = 0;
    endtask

    task automatic step();
        @(negedge clk);
        clear_pulses();
    endtask

    function automatic logic [3:0] model(input logic [5:0] p, input logic [3:0] m);
        if (p[0])             return 4'b0111;
        if (p[1] && m[2])     return 4'b0110;
        if (p[2] && m[0])     return 4'b0100;
        if (p[3] && m[0])     return 4'b1100;
        if (p[4] && m[1])     return 4'b0010;
        if (p[5] && m[3])     return 4'b0000;
        return 4'b0001;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        set_en(8'h00);
        fifo_en = 0;
        do_reset();
        // R1 reset state
        check8("R1 iir after reset", iir, 8'h01);
        check8("R1 irq after reset", {7'd0, irq}, 8'h00);

        // Sweep: every source subset x every enable mask x fifo on/off (R2 R3 R4 R11)
        for (int f = 0; f < 2; f++) begin
            for (int m = 0; m < 16; m++) begin
                for (int p = 0; p < 64; p++) begin
                    set_en({4'b0000, 4'(m)});
                    fifo_en = f[0];
                    do_reset();
                    lcr_wr = p[0]; uart_busy = p[0];
                    line_err = p[1];
                    rx_trig = p[2];
                    rx_timeout = p[3];
                    thr_empty = p[4];
                    modem_delta = p[5];
                    step();
                    check_id("R2 R3 R4 R11 sweep", model(6'(p), 4'(m)));
                end
            end
        end

        // R11 bits 7:6 follow fifo_en
        set_en(8'h0F); fifo_en = 1; do_reset();
        check8("R11 fifo on", iir, 8'hC1);
        fifo_en = 0; #1;
        check8("R11 fifo off", iir, 8'h01);
        fifo_en = 1;

        // R5 line status set, clear, set-wins
        line_err = 1; step();
        check_id("R5 line set", 4'b0110);
        lsr_rd = 1; step();
        check_id("R5 line clear", 4'b0001);
        line_err = 1; lsr_rd = 1; step();
        check_id("R5 set wins", 4'b0110);
        lsr_rd = 1; step();

        // R4 masked source kept, shown once enabled
        set_en(8'h0B); line_err = 1; step();
        check_id("R4 masked line", 4'b0001);
        set_en(8'h0F); #1;
        check_id("R4 unmasked line", 4'b0110);
        lsr_rd = 1; step();

        // R6 data level and timeout
        rx_trig = 1; #1;
        check_id("R6 data same cycle", 4'b0100);
        rx_trig = 0; #1;
        check_id("R6 data drop", 4'b0001);
        rx_timeout = 1; step();
        check_id("R6 timeout set", 4'b1100);
        rbr_rd = 1; step();
        check_id("R6 timeout clear", 4'b0001);

        // R7 transmit empty: read ack, enable re-arm, write ack, condition re-arm
        thr_empty = 1; step();
        check_id("R7 txe armed", 4'b0010);
        iir_rd = 1; step();
        check_id("R7 read ack", 4'b0001);
        step(); step();
        check_id("R7 stays acked", 4'b0001);
        set_en(8'h0D); step();
        set_en(8'h0F); step();
        check_id("R7 enable rearm", 4'b0010);
        thr_wr = 1; step();
        check_id("R7 write ack", 4'b0001);
        thr_empty = 0; step();
        thr_empty = 1; step();
        check_id("R7 condition rearm", 4'b0010);
        thr_empty = 0; step();
        check_id("R7 condition gone", 4'b0001);

        // R8 programmable threshold mode
        set_en(8'h8F); fifo_en = 1; do_reset();
        tx_below = 1; step();
        check_id("R8 threshold arms", 4'b0010);
        tx_below = 0; thr_empty = 1; step();
        check_id("R8 empty ignored", 4'b0001);
        fifo_en = 0; do_reset();
        tx_below = 1; step();
        check_id("R8 no fifo threshold ignored", 4'b0001);
        thr_empty = 1; step();
        check_id("R8 no fifo uses empty", 4'b0010);

        // R9 busy detect
        set_en(8'h00); fifo_en = 0; do_reset();
        lcr_wr = 1; uart_busy = 0; step();
        check_id("R9 idle write ignored", 4'b0001);
        lcr_wr = 1; uart_busy = 1; step();
        check_id("R9 busy write", 4'b0111);
        uart_busy = 0; usr_rd = 1; step();
        check_id("R9 status read clears", 4'b0001);

        // R10 modem status
        set_en(8'h08); do_reset();
        modem_delta = 1; step();
        check_id("R10 modem set", 4'b0000);
        msr_rd = 1; step();
        check_id("R10 modem clear", 4'b0001);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule